// File: doc/BRIEF.md
# Reloadable Tick Event Down-Counter

This block is a decrementing tick timer that gives an operating system either a single timeout or a steady stream of scheduling interrupts without needing a processor-side timer. It counts the strobes of an already prescaled low-frequency tick. Software programs a load value and copies it into the live count with a one-shot apply command. It then enables counting and chooses between single-event and auto-reload operation.

When a tick arrives while the live count is zero, the timer raises a sticky event flag. It then either reloads the count from the programmed load value or parks at zero until software applies a new value. The event flag is cleared by writing 1 to it and drives an interrupt line through an enable bit. All state is reached through a small word-wide register interface with a registered read port.

Top module: `tick_down_timer`

## Requirements
- R1: After a synchronous reset the live count, the event flag, the control bits, the load value and `irq_o` are all 0, the interrupt enable (address 3, bit 0) is 1, and `rd_data_o` is 0.
- R2: Writing address 0 with bit 2 set applies the load value (address 1) to the live count on that clock edge and arms the timer; bit 2 is a command and reads back as 0.
- R3: While run (address 0, bit 0) is 1 and the timer is armed, each `tick_i` strobe lowers a nonzero count by one; with run at 0, ticks leave the count unchanged and raise no event.
- R4: A tick that finds an armed, running timer at count 0 sets the event flag (address 2, bit 0) on that edge.
- R5: With auto-reload (address 0, bit 1) at 1, the event tick also copies the load value into the count, so a load value N gives one event every N+1 ticks.
- R6: With auto-reload at 0, the event tick disarms the timer: the count holds at 0 and later ticks raise no event until the next apply.
- R7: A load value of 0 raises an event on the first tick after apply and, in auto-reload mode, on every following tick.
- R8: Writing 1 to address 2 bit 0 clears the event flag and writing 0 leaves it; an event on the same edge as a clearing write leaves the flag set.
- R9: `irq_o` is 1 exactly when the event flag and the interrupt enable are both 1.
- R10: `rd_data_o` shows, one clock after `rd_addr` is presented, the register at that address; address 4 gives the live count.
- R11: Ticks before the first apply after reset raise no event and leave the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle prescaled tick strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data_o | output | CNT_W | Registered read data |
| irq_o | output | 1 | Tick event interrupt |

## Verification
The bench builds the block with a 16-bit count, which keeps the load values and read data short while leaving every mode decision unchanged. Small load values of 0, 3 and 5 bring one-shot stops, reload periods and the every-tick case within a few dozen cycles. A clearing write is placed on the very edge of an event to reach the flag priority case. Ticks are issued with idle cycles between them, so that a count step which fails to wait for its strobe shows up.

// File: rtl/tick_dn_pkg.sv
package tick_dn_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_LOAD  = 3'd1,
    A_STAT  = 3'd2,
    A_IEN   = 3'd3,
    A_COUNT = 3'd4
  } reg_addr_e;

  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_AUTO  = 1;
  localparam int unsigned B_APPLY = 2;
endpackage

// File: rtl/tick_dn_core.sv
module tick_dn_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             auto_i,
  input  logic             apply_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] count_o,
  output logic             evt_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             armed_q;
  logic             step;
  logic             at_zero;

  assign step    = tick_i && run_i && armed_q;
  assign at_zero = (count_q == ZERO);
  assign evt_o   = step && at_zero && !apply_i;
  assign count_o = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= ZERO;
      armed_q <= 1'b0;
    end else if (apply_i) begin
      count_q <= load_i;
      armed_q <= 1'b1;
    end else if (step) begin
      if (at_zero) begin
        if (auto_i) count_q <= load_i;
        else        armed_q <= 1'b0;
      end else begin
        count_q <= count_q - ONE;
      end
    end
  end

  p_apply_load_r2: assert property (@(posedge clk) disable iff (rst)
    apply_i |=> (count_q == $past(load_i)));
  p_decrement_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_i && run_i && armed_q && !at_zero && !apply_i) |=> (count_q == $past(count_q) - ONE));
  p_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    (!apply_i && !(tick_i && run_i)) |=> $stable(count_q));
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (evt_o && auto_i) |=> (count_q == $past(load_i)));
  p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_o && !auto_i) |=> (!armed_q && count_q == ZERO));
endmodule

// File: rtl/tick_dn_regs.sv
module tick_dn_regs
  import tick_dn_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              evt_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              run_o,
  output logic              auto_o,
  output logic              apply_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              irq_o,
  output logic [CNT_W-1:0]  rd_data_o
);
  logic             run_q, auto_q, flag_q, ie_q, irq_q;
  logic [CNT_W-1:0] load_q, rd_q, rd_d;
  logic             flag_d, ie_d;
  logic             ctrl_wr, load_wr, stat_wr, ien_wr;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign load_wr = wr_en && (wr_addr == A_LOAD);
  assign stat_wr = wr_en && (wr_addr == A_STAT);
  assign ien_wr  = wr_en && (wr_addr == A_IEN);

  assign apply_o = ctrl_wr && wr_data[B_APPLY];

  always_comb begin
    if (evt_i)                       flag_d = 1'b1;
    else if (stat_wr && wr_data[0])  flag_d = 1'b0;
    else                             flag_d = flag_q;
    ie_d = ien_wr ? wr_data[0] : ie_q;
  end

  always_comb begin
    rd_d = '0;
    case (rd_addr)
      A_CTRL:  begin rd_d[B_RUN] = run_q; rd_d[B_AUTO] = auto_q; end
      A_LOAD:  rd_d = load_q;
      A_STAT:  rd_d[0] = flag_q;
      A_IEN:   rd_d[0] = ie_q;
      A_COUNT: rd_d = count_i;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      auto_q <= 1'b0;
      load_q <= '0;
      flag_q <= 1'b0;
      ie_q   <= 1'b1;
      irq_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (ctrl_wr) begin
        run_q  <= wr_data[B_RUN];
        auto_q <= wr_data[B_AUTO];
      end
      if (load_wr) load_q <= wr_data;
      flag_q <= flag_d;
      ie_q   <= ie_d;
      irq_q  <= flag_d && ie_d;
      rd_q   <= rd_d;
    end
  end

  assign run_o     = run_q;
  assign auto_o    = auto_q;
  assign load_o    = load_q;
  assign irq_o     = irq_q;
  assign rd_data_o = rd_q;

  p_flag_source_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(evt_i));
  p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && wr_data[0] && !evt_i) |=> !flag_q);
  p_evt_sets_r8: assert property (@(posedge clk) disable iff (rst)
    evt_i |=> flag_q);
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (!flag_q || !ie_q) |-> !irq_o);
endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import tick_dn_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              irq_o
);
  logic             run, auto_rl, apply, evt;
  logic [CNT_W-1:0] load_val, count;

  tick_dn_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .evt_i     (evt),
    .count_i   (count),
    .run_o     (run),
    .auto_o    (auto_rl),
    .apply_o   (apply),
    .load_o    (load_val),
    .irq_o     (irq_o),
    .rd_data_o (rd_data_o)
  );

  tick_dn_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .run_i   (run),
    .auto_i  (auto_rl),
    .apply_i (apply),
    .load_i  (load_val),
    .count_o (count),
    .evt_o   (evt)
  );
endmodule

// File: tb/test_tick_down_timer.sv
module test_tick_down_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_i = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data_o;
  logic         irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_down_timer #(.CNT_W(W)) i_tick_down_timer (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_addr = 3'(a);
    @(negedge clk);
    v = int'(rd_data_o);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    int v;
    chk("R1", "irq", int'(irq_o), 0);
    chk("R1", "rd_data", int'(rd_data_o), 0);
    rd(4, v); chk("R1", "count", v, 0);
    rd(3, v); chk("R1", "ien", v, 1);
    rd(2, v); chk("R1", "flag", v, 0);
    rd(0, v); chk("R1", "ctrl", v, 0);
  endtask

  task automatic t_unarmed;
    int v;
    wr(0, 1);
    ticks(3);
    rd(2, v); chk("R11", "flag unarmed", v, 0);
    rd(4, v); chk("R11", "count unarmed", v, 0);
  endtask

  task automatic t_load_run;
    int v;
    wr(1, 5);
    wr(0, 5);
    rd(4, v); chk("R2", "count after apply", v, 5);
    rd(0, v); chk("R2", "ctrl readback", v, 1);
    ticks(2);
    rd(4, v); chk("R3", "count after 2 ticks", v, 3);
    wr(0, 0);
    ticks(2);
    rd(4, v); chk("R3", "frozen count", v, 3);
    rd(2, v); chk("R3", "no event when stopped", v, 0);
  endtask

  task automatic t_oneshot;
    int v;
    wr(0, 1);
    ticks(3);
    rd(4, v); chk("R4", "count at zero", v, 0);
    rd(2, v); chk("R4", "no flag before event tick", v, 0);
    ticks(1);
    rd(2, v); chk("R4", "flag on event", v, 1);
    chk("R9", "irq with flag", int'(irq_o), 1);
    wr(2, 0);
    rd(2, v); chk("R8", "write 0 keeps flag", v, 1);
    wr(2, 1);
    rd(2, v); chk("R8", "write 1 clears flag", v, 0);
    chk("R9", "irq after clear", int'(irq_o), 0);
    ticks(3);
    rd(2, v); chk("R6", "no event after stop", v, 0);
    rd(4, v); chk("R6", "count held at 0", v, 0);
    wr(0, 5);
    rd(4, v); chk("R6", "rearm reloads", v, 5);
  endtask

  task automatic t_auto;
    int v;
    wr(1, 3);
    wr(0, 7);
    rd(0, v); chk("R10", "ctrl run+auto", v, 3);
    rd(1, v); chk("R10", "load readback", v, 3);
    ticks(3);
    rd(2, v); chk("R5", "no flag mid-period", v, 0);
    ticks(1);
    rd(2, v); chk("R5", "flag at period end", v, 1);
    rd(4, v); chk("R5", "count reloaded", v, 3);
    wr(3, 0);
    chk("R9", "irq masked", int'(irq_o), 0);
    wr(3, 1);
    chk("R9", "irq unmasked", int'(irq_o), 1);
    wr(2, 1);
    ticks(3);
    rd(2, v); chk("R5", "second period quiet", v, 0);
    ticks(1);
    rd(2, v); chk("R5", "second event", v, 1);
    wr(2, 1);
  endtask

  task automatic t_zero_load;
    int v;
    wr(1, 0);
    wr(0, 7);
    ticks(1);
    rd(2, v); chk("R7", "first tick event", v, 1);
    wr(2, 1);
    ticks(1);
    rd(2, v); chk("R7", "repeat every tick", v, 1);
    rd(4, v); chk("R7", "count stays 0", v, 0);
    wr(2, 1);
    @(negedge clk);
    tick_i = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = W'(1);
    @(negedge clk);
    tick_i = 1'b0; wr_en = 1'b0;
    rd(2, v); chk("R8", "event wins over clear", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unarmed();
    t_load_run();
    t_oneshot();
    t_auto();
    t_zero_load();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule